// File: doc/BRIEF.md
# Programmable Scaled Clock Prescaler

This block turns an incoming clock enable into a slower clock enable. The incoming enable, `tick_in`, is a one-cycle pulse on the system clock that stands for an already prescaled clock. An 8-bit scale register sets the division ratio. The block emits one single-cycle pulse on `tick_out` for every `2 × N` accepted input ticks, where N is the scale value and a stored value of zero counts as 256. A PWM channel can select `tick_out` as its counting clock. Every signal stays in the one system-clock domain.

Software loads the scale register through a write strobe with write data, and reads it back on `rd_data` at any time. Any write restarts the division from a fixed phase, even when the value written is unchanged. A write therefore takes effect at once and does not wait for the current period to end.

Inside, a scale register feeds a down-counter. The down-counter steps on each accepted tick and reloads at terminal count. A two-state phase machine toggles on each terminal count and fires the output pulse on the toggle that closes a full period. The two states are `PH_LOW` and `PH_HIGH`. The machine has three transitions:
- `PH_LOW` goes to `PH_HIGH` on a terminal count.
- `PH_HIGH` goes to `PH_LOW` on a terminal count, and this transition emits the pulse.
- Either state goes to `PH_LOW` on a write, and no pulse is emitted.

Top module: `scl_prescaler`

## Requirements
- R1: With a nonzero scale value N, `tick_out` pulses once for every 2×N accepted `tick_in` pulses, counted from the last reload.
- R2: A scale value of 0x00 divides by 512, so a pulse follows every 512 accepted ticks.
- R3: Every write, including a write of the value already held, restarts the count. The next pulse comes after 2×N further accepted ticks, where N is the new value, and no pulse is output in the cycle after the write.
- R4: A `tick_in` in the same cycle as `wr_en` is not counted.
- R5: `rd_data` shows the scale register. It takes the value of `wr_data` in the cycle after a write, and it holds its value when no write occurs.
- R6: Synchronous active-high reset clears the scale register to 0x00 and clears `tick_out`. The first pulse after reset comes after 512 accepted ticks.
- R7: `tick_out` is high for exactly one system-clock cycle. It rises only in the cycle right after the accepted `tick_in` that completes a period.
- R8: Cycles without `tick_in` do not advance the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | Input clock enable, one cycle wide |
| wr_en | input | 1 | Write strobe for the scale register |
| wr_data | input | 8 | Scale value to write |
| rd_data | output | 8 | Current scale value |
| tick_out | output | 1 | Scaled clock enable, one cycle wide |

## Verification
Both results are due one clock after the cycle that causes them. A `tick_out` pulse appears in the cycle after the accepted tick that closes a period. `rd_data` shows new write data one cycle after the strobe. The bench drives each stimulus on the falling edge. It lets one rising edge pass and compares at the next falling edge against a reference. That reference only counts accepted ticks since the last write or reset and tests divisibility by 2×N. Scale values 1 to 7, 255 and 0 are swept under dense, sparse and pseudo-random tick patterns. The sweep includes writes that coincide with ticks and same-value rewrites in mid-period.

// File: rtl/scl_pkg.sv
package scl_pkg;
    // Phase of the divide-by-two stage
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } scl_phase_e;
endpackage

// File: rtl/scl_scale_reg.sv
module scl_scale_reg #(
    parameter int SCALE_W = 8,
    parameter int CNT_W   = SCALE_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [SCALE_W-1:0] wr_data,
    output logic [SCALE_W-1:0] scale_q,
    output logic [CNT_W-1:0]   cur_count,   // count length from held value
    output logic [CNT_W-1:0]   new_count    // count length from write data
);
    localparam logic [CNT_W-1:0] FULL_COUNT = CNT_W'(1) << SCALE_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            scale_q <= '0;
        end else if (wr_en) begin
            scale_q <= wr_data;
        end
    end

    // A zero scale stands for the full range
    always_comb begin
        cur_count = (scale_q == '0) ? FULL_COUNT : CNT_W'(scale_q);
        new_count = (wr_data == '0) ? FULL_COUNT : CNT_W'(wr_data);
    end
endmodule

// File: rtl/scl_down_cnt.sv
module scl_down_cnt #(
    parameter int SCALE_W = 8,
    parameter int CNT_W   = SCALE_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             step,
    output logic             term
);
    localparam logic [CNT_W-1:0] FULL_COUNT = CNT_W'(1) << SCALE_W;
    localparam logic [CNT_W-1:0] ONE        = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Terminal step: last tick of a half period
    always_comb begin
        term = step && !load && (cnt_q == ONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= FULL_COUNT;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (term) begin
            cnt_q <= reload_val;
        end else if (step) begin
            cnt_q <= cnt_q - ONE;
        end
    end
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic term,
    output logic pulse
);
    scl_phase_e state_q, state_d;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        if (restart) begin
            state_d = PH_LOW;
        end else if (term) begin
            unique case (state_q)
                PH_LOW:  state_d = PH_HIGH;
                PH_HIGH: state_d = PH_LOW;
                default: state_d = PH_LOW;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: pulse when a full period closes
    always_ff @(posedge clk) begin
        if (rst) begin
            pulse <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (!restart && term) begin
                unique case (state_q)
                    PH_LOW:  pulse <= 1'b0;
                    PH_HIGH: pulse <= 1'b1;
                    default: pulse <= 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
    parameter int SCALE_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick_in,
    input  logic               wr_en,
    input  logic [SCALE_W-1:0] wr_data,
    output logic [SCALE_W-1:0] rd_data,
    output logic               tick_out
);
    localparam int CNT_W = SCALE_W + 1;

    logic [CNT_W-1:0] cur_count;
    logic [CNT_W-1:0] new_count;
    logic             half_done;

    scl_scale_reg #(.SCALE_W(SCALE_W), .CNT_W(CNT_W)) u_scale (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .scale_q   (rd_data),
        .cur_count (cur_count),
        .new_count (new_count)
    );

    scl_down_cnt #(.SCALE_W(SCALE_W), .CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load       (wr_en),
        .load_val   (new_count),
        .reload_val (cur_count),
        .step       (tick_in),
        .term       (half_done)
    );

    scl_phase_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .restart (wr_en),
        .term    (half_done),
        .pulse   (tick_out)
    );
endmodule

// File: rtl/scl_prescaler_chk.sv
module scl_prescaler_chk #(
    parameter int SCALE_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               tick_in,
    input logic               wr_en,
    input logic [SCALE_W-1:0] wr_data,
    input logic [SCALE_W-1:0] rd_data,
    input logic               tick_out
);
    AST_PULSE_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
        tick_out |=> !tick_out); // R7

    AST_PULSE_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        tick_out |-> ($past(tick_in) && !$past(wr_en))); // R4

    AST_WRITE_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !tick_out); // R3

    AST_READ_TAKES_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data == $past(wr_data))); // R5

    AST_READ_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(rd_data)); // R5

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> ((rd_data == '0) && !tick_out)); // R6
endmodule

bind scl_prescaler scl_prescaler_chk #(.SCALE_W(SCALE_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick_in  (tick_in),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .tick_out (tick_out)
);

// File: tb/scl_prescaler_tb.sv
module scl_prescaler_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       tick_out;

    int checks = 0;
    int errors = 0;

    // reference state
    int  ref_scale = 0;
    int  ref_ticks = 0;
    logic exp_out  = 1'b0;
    logic prev_exp = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    scl_prescaler u_dut (
        .clk      (clk),
        .rst      (rst),
        .tick_in  (tick_in),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .tick_out (tick_out)
    );

    function automatic int eff_n(input int s);
        return (s == 0) ? 256 : s;
    endfunction

    // one clock: drive at falling edge, compare at the next falling edge
    task automatic step(input logic t, input logic w, input logic [7:0] d);
        string tag;
        tick_in = t;
        wr_en   = w;
        wr_data = d;
        prev_exp = exp_out;
        if (w) begin
            ref_scale = d;
            ref_ticks = 0;
            exp_out   = 1'b0;
            tag = t ? "R4" : "R3";
        end else if (t) begin
            ref_ticks = ref_ticks + 1;
            exp_out = ((ref_ticks % (2 * eff_n(ref_scale))) == 0);
            tag = (ref_scale == 0) ? "R2" : "R1";
        end else begin
            exp_out = 1'b0;
            tag = "R8";
        end
        if (prev_exp) tag = "R7";
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (tick_out !== exp_out) begin
            errors++;
            $display("FAIL %s tick_out actual %0b expected %0b (scale %0d ticks %0d)",
                     tag, tick_out, exp_out, ref_scale, ref_ticks);
        end
        checks++;
        if (rd_data !== 8'(ref_scale)) begin
            errors++;
            $display("FAIL R5 rd_data actual %0d expected %0d", rd_data, ref_scale);
        end
    endtask

    task automatic do_reset();
        tick_in = 1'b0;
        wr_en   = 1'b0;
        rst     = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        ref_scale = 0;
        ref_ticks = 0;
        exp_out   = 1'b0;
        checks++;
        if (rd_data !== 8'h00 || tick_out !== 1'b0) begin
            errors++;
            $display("FAIL R6 reset rd_data %0d tick_out %0b expected 0 0", rd_data, tick_out);
        end
    endtask

    function automatic logic pat(input int mode, input int i);
        case (mode)
            0: return 1'b1;
            1: return (i % 2) == 0;
            2: return (i % 3) == 1;
            default: return lfsr[0];
        endcase
    endfunction

    task automatic run(input int mode, input int n);
        for (int i = 0; i < n; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(pat(mode, i), 1'b0, 8'h00);
        end
    endtask

    initial begin : watchdog
        #700000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int scales[9] = '{1, 2, 3, 4, 5, 6, 7, 255, 0};
        @(negedge clk);
        do_reset();
        // R6: first period after reset uses 512 ticks
        run(0, 1030);

        foreach (scales[k]) begin
            for (int mode = 0; mode < 4; mode++) begin
                step(1'b0, 1'b1, 8'(scales[k]));
                run(mode, (mode == 0 ? 3 : 4) * 2 * eff_n(scales[k]) + 6);
            end
        end

        // R3: same-value rewrite mid-period pushes the pulse out
        step(1'b0, 1'b1, 8'd5);
        run(0, 7);
        step(1'b0, 1'b1, 8'd5);
        run(0, 25);
        // R4: write coinciding with a tick
        step(1'b1, 1'b1, 8'd3);
        run(0, 14);
        step(1'b1, 1'b1, 8'd3);
        run(3, 30);
        // R8: long idle gap keeps the count
        step(1'b0, 1'b1, 8'd2);
        run(0, 3);
        for (int i = 0; i < 20; i++) step(1'b0, 1'b0, 8'h00);
        run(0, 10);

        // R6: reset mid-run, then 512-tick period
        run(0, 3);
        do_reset();
        run(0, 520);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule